// File: doc/BRIEF.md
# Pulse-Handshake Bus Request/Grant Controller

This block sits in a processor's bus interface and lets other local masters borrow the local bus. Each request/grant line is a single shared, active-low wire that carries one-clock pulses in both directions. A neighbouring master pulls the wire low for one clock to ask for the bus. The controller answers on the same wire with a one-clock grant pulse, floats the bus from the next clock on, and waits for a third one-clock pulse from the master. That third pulse hands the bus back. The controller then signals its bus sequencer to resume in T4. It also inserts one mandatory idle clock before it can grant again.

Release timing follows the processor's own bus activity. The sequencer reports the current phase on `bus_phase`, where 0 means idle, 1 means T1, 2 means T2, 3 means T3 and 4 means T4. When the bus is idle, a pending request is granted at once. During an active cycle, a grant can only be given in T4, and only when all of these hold:
- the request arrived early enough in the cycle;
- the cycle is not the low half of a split word;
- the cycle is not the first cycle of an interrupt-acknowledge pair;
- no locked instruction is running.

The controller also drives the active-low lock output and its enable, and it floats that output while the bus is lent out.

Top module: `rqgt_ctrl`

## Requirements
- R1: During and right after reset, no line is pulled low, `bus_float` and `resume_t4` are 0 and `lock_oe` is 1.
- R2: A request is a 0 on `rg_line_n[i]` for one clock while the controller is not pulling that line. If the bus is idle (phase 0), the controller pulls the requesting line low (`rg_pull_low[i]`=1) in the very next clock, for exactly one clock.
- R3: `bus_float` rises in the clock after the grant pulse. It stays 1 until the owning master pulls its line low for one clock.
- R4: In the clock after that release pulse, `resume_t4` is 1 for one clock and `bus_float` is 0.
- R5: No grant is given in the clock after `resume_t4`. A request left pending is granted in the clock after that idle gap.
- R6: When line 0 and line 1 are pending together, line 0 is granted first and line 1 is served after line 0's exchange ends.
- R7: During an active cycle, a grant is given only in a T4 clock (phase 4), and only when the request arrived in a clock with phase 0, 1 or 2.
- R8: A request that arrives in T3 (phase 3) or in T4 is not granted in that cycle's T4. It is granted in the T4 of a following cycle, once that cycle's T1 (phase 1) has been seen.
- R9: No grant is given in a T4 clock while `low_byte_xfer` or `inta_first_cyc` is 1. The request stays pending for a later T4.
- R10: While `lock_active` is 1, no grant is given in any phase. Pending requests are kept.
- R11: `lock_n` is the inverse of `lock_active`. `lock_oe` is 0 whenever `bus_float` is 1, and 1 otherwise.
- R12: The controller never treats its own grant pulse as a request. A pulse on another line during an exchange is held as pending and served after the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rg_line_n | input | NLINES | Sampled level of each shared request/grant wire (active low) |
| rg_pull_low | output | NLINES | Pull the matching wire low this clock (grant pulse) |
| bus_phase | input | 3 | Bus cycle phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4 |
| low_byte_xfer | input | 1 | Current cycle is the low half of a word transfer |
| inta_first_cyc | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| lock_active | input | 1 | A locked instruction is executing |
| bus_float | output | 1 | Bus is lent out (hold acknowledge) |
| resume_t4 | output | 1 | One-clock pulse telling the sequencer to take the bus back in T4 |
| lock_n | output | 1 | Lock output, active low |
| lock_oe | output | 1 | Output enable for the lock pin |

## Verification
The grant pulse depends combinationally on the current phase and flags. For an idle bus it is due one clock after the request pulse, and for an active cycle it is due in the qualifying T4 clock itself. `bus_float` is due one clock after the grant. `resume_t4` is due one clock after the release pulse, and a deferred grant comes two clocks after `resume_t4`. The bench drives inputs on the falling edge and records the absolute cycle at which each result is due in a scoreboard queue. A monitor samples 3 ns after each falling edge and compares every grant, float rise and resume pulse against the head of that queue, cycle number included. Any early, late, missing or extra event is therefore reported.

// File: rtl/rqgt_pkg.sv
`timescale 1ns/1ps
package rqgt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RECLAIM = 2'd2,
        ST_GAP     = 2'd3
    } hold_st_e;

    // a request seen in idle, T1 or T2 meets the timing rule of the current cycle
    function automatic logic phase_is_early(input phase_e p);
        return (p == PH_IDLE) || (p == PH_T1) || (p == PH_T2);
    endfunction

endpackage

// File: rtl/rqgt_req_latch.sv
`timescale 1ns/1ps
module rqgt_req_latch
    import rqgt_pkg::*;
#(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_n,
    input  logic [NLINES-1:0] self_drive,
    input  logic [NLINES-1:0] hold_sel,
    input  logic [NLINES-1:0] take,
    input  phase_e            phase,
    output logic [NLINES-1:0] pend,
    output logic [NLINES-1:0] early
);

    typedef struct packed {
        logic [NLINES-1:0] pend;
        logic [NLINES-1:0] early;
    } lat_t;

    lat_t              st_d, st_q;
    logic [NLINES-1:0] seen;

    // a low level counts as a request unless it is our own grant or the owner's release
    for (genvar g = 0; g < NLINES; g++) begin : g_seen
        assign seen[g] = ~line_n[g] & ~self_drive[g] & ~hold_sel[g];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NLINES; i++) begin
            if (take[i]) begin
                st_d.pend[i]  = 1'b0;
                st_d.early[i] = 1'b0;
            end else if (seen[i] && !st_q.pend[i]) begin
                st_d.pend[i]  = 1'b1;
                st_d.early[i] = phase_is_early(phase);
            end else if (st_q.pend[i] && phase == PH_T1) begin
                st_d.early[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend  = st_q.pend;
    assign early = st_q.early;

endmodule

// File: rtl/rqgt_release_gate.sv
`timescale 1ns/1ps
module rqgt_release_gate
    import rqgt_pkg::*;
#(
    parameter int NLINES = 2
) (
    input  logic [NLINES-1:0] pend,
    input  logic [NLINES-1:0] early,
    input  phase_e            phase,
    input  logic              low_byte,
    input  logic              inta_first,
    input  logic              locked,
    input  logic              may_grant,
    output logic [NLINES-1:0] grant
);

    logic [NLINES-1:0] pick;
    logic              pick_early;
    logic              t4_ok;
    logic              window_ok;

    always_comb begin
        // lowest index wins
        pick       = pend & NLINES'(~pend + 1'b1);
        pick_early = |(pick & early);
        t4_ok      = (phase == PH_T4) && pick_early && !low_byte && !inta_first;
        window_ok  = (phase == PH_IDLE) || t4_ok;
        grant      = (may_grant && window_ok && !locked) ? pick : '0;
    end

endmodule

// File: rtl/rqgt_hold_fsm.sv
`timescale 1ns/1ps
module rqgt_hold_fsm
    import rqgt_pkg::*;
#(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] grant,
    input  logic [NLINES-1:0] line_n,
    output logic [NLINES-1:0] hold_sel,
    output logic              bus_float,
    output logic              resume,
    output logic              may_grant
);

    typedef struct packed {
        hold_st_e          st;
        logic [NLINES-1:0] owner;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_OWN: begin
                if (|grant) begin
                    fsm_d.st    = ST_HOLD;
                    fsm_d.owner = grant;
                end
            end
            ST_HOLD: begin
                if (|(fsm_q.owner & ~line_n)) begin
                    fsm_d.st = ST_RECLAIM;
                end
            end
            ST_RECLAIM: begin
                fsm_d.st = ST_GAP;
            end
            ST_GAP: begin
                fsm_d.st    = ST_OWN;
                fsm_d.owner = '0;
            end
            default: fsm_d.st = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_OWN, owner: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign bus_float = (fsm_q.st == ST_HOLD);
    assign resume    = (fsm_q.st == ST_RECLAIM);
    assign may_grant = (fsm_q.st == ST_OWN);
    assign hold_sel  = (fsm_q.st == ST_HOLD) ? fsm_q.owner : '0;

endmodule

// File: rtl/rqgt_ctrl.sv
`timescale 1ns/1ps
module rqgt_ctrl
    import rqgt_pkg::*;
#(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] rg_line_n,
    output logic [NLINES-1:0] rg_pull_low,
    input  logic [2:0]        bus_phase,
    input  logic              low_byte_xfer,
    input  logic              inta_first_cyc,
    input  logic              lock_active,
    output logic              bus_float,
    output logic              resume_t4,
    output logic              lock_n,
    output logic              lock_oe
);

    phase_e            phase;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] early;
    logic [NLINES-1:0] grant;
    logic [NLINES-1:0] hold_sel;
    logic              may_grant;

    assign phase = phase_e'(bus_phase);

    rqgt_req_latch #(.NLINES(NLINES)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n     (rg_line_n),
        .self_drive (grant),
        .hold_sel   (hold_sel),
        .take       (grant),
        .phase      (phase),
        .pend       (pend),
        .early      (early)
    );

    rqgt_release_gate #(.NLINES(NLINES)) u_gate (
        .pend       (pend),
        .early      (early),
        .phase      (phase),
        .low_byte   (low_byte_xfer),
        .inta_first (inta_first_cyc),
        .locked     (lock_active),
        .may_grant  (may_grant),
        .grant      (grant)
    );

    rqgt_hold_fsm #(.NLINES(NLINES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .line_n    (rg_line_n),
        .hold_sel  (hold_sel),
        .bus_float (bus_float),
        .resume    (resume_t4),
        .may_grant (may_grant)
    );

    assign rg_pull_low = grant;
    assign lock_n      = ~lock_active;
    assign lock_oe     = ~bus_float;

endmodule

// File: rtl/rqgt_ctrl_chk.sv
`timescale 1ns/1ps
module rqgt_ctrl_chk #(
    parameter int NLINES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] rg_pull_low,
    input logic [2:0]        bus_phase,
    input logic              low_byte_xfer,
    input logic              inta_first_cyc,
    input logic              lock_active,
    input logic              bus_float,
    input logic              resume_t4,
    input logic              lock_oe
);

    AST_GRANT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_pull_low) |-> (bus_phase == 3'd0 || bus_phase == 3'd4)); // R7

    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rg_pull_low)); // R6

    AST_GRANT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_pull_low) |=> !(|rg_pull_low)); // R2

    AST_FLOAT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_pull_low) |=> bus_float); // R3

    AST_RESUME_ON_RECLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_float) |-> resume_t4); // R4

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        resume_t4 |=> !(|rg_pull_low)); // R5

    AST_SPLIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 3'd4 && (low_byte_xfer || inta_first_cyc)) |-> !(|rg_pull_low)); // R9

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> !(|rg_pull_low)); // R10

    AST_LOCK_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_float |-> !lock_oe); // R11

endmodule

bind rqgt_ctrl rqgt_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rg_pull_low    (rg_pull_low),
    .bus_phase      (bus_phase),
    .low_byte_xfer  (low_byte_xfer),
    .inta_first_cyc (inta_first_cyc),
    .lock_active    (lock_active),
    .bus_float      (bus_float),
    .resume_t4      (resume_t4),
    .lock_oe        (lock_oe)
);

// File: tb/sim_rqgt_ctrl.sv
`timescale 1ns/1ps
module sim_rqgt_ctrl;

    localparam int NL        = 2;
    localparam int EV_GRANT  = 0;
    localparam int EV_FLOAT  = 1;
    localparam int EV_RESUME = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] pull_m = '0;
    logic [NL-1:0] pull_dut;
    logic [NL-1:0] line_n;
    logic [2:0]    ph = 3'd0;
    logic          lb = 1'b0, ia = 1'b0, lk = 1'b0;
    logic          flt, res, lkn, lkoe;
    logic          prev_flt = 1'b0, prev_drv = 1'b0;
    logic          done = 1'b0;
    int            cyc = 0;
    int            n_chk = 0, n_fail = 0;
    int            c;

    typedef struct {
        int    kind;
        int    line;
        int    at;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // wired-low shared lines: either side may pull
    assign line_n = ~(pull_m | pull_dut);

    rqgt_ctrl #(.NLINES(NL)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .rg_line_n      (line_n),
        .rg_pull_low    (pull_dut),
        .bus_phase      (ph),
        .low_byte_xfer  (lb),
        .inta_first_cyc (ia),
        .lock_active    (lk),
        .bus_float      (flt),
        .resume_t4      (res),
        .lock_n         (lkn),
        .lock_oe        (lkoe)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int k, input int l, input int at, input string req);
        exp_t e;
        e.kind = k; e.line = l; e.at = at; e.req = req;
        sb.push_back(e);
    endtask

    task automatic take_ev(input int k, input int l);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, "R12", $sformatf("unexpected event kind %0d line %0d cycle", k, l), cyc, -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == k && e.line == l && e.at == cyc, e.req,
                  $sformatf("event kind %0d/%0d line %0d/%0d cycle", k, e.kind, l, e.line), cyc, e.at);
        end
    endtask

    task automatic step(input int p, input bit r0, input bit r1,
                        input bit l_b = 1'b0, input bit i_a = 1'b0, input bit l_k = 1'b0);
        @(negedge clk);
        ph = 3'(p); pull_m = {r1, r0}; lb = l_b; ia = i_a; lk = l_k;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: compares observed events with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                for (int i = 0; i < NL; i++) if (pull_dut[i]) take_ev(EV_GRANT, i);
                if (|pull_dut) check(!prev_drv, "R2", "grant pulse width", 2, 1);
                if (flt && !prev_flt) take_ev(EV_FLOAT, 0);
                if (res) take_ev(EV_RESUME, 0);
            end
            prev_flt = flt;
            prev_drv = |pull_dut;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // reset state (R1)
        repeat (3) @(negedge clk);
        #3;
        check(pull_dut == '0, "R1", "pull in reset", int'(pull_dut), 0);
        check(flt == 1'b0, "R1", "float in reset", int'(flt), 0);
        check(res == 1'b0, "R1", "resume in reset", int'(res), 0);
        check(lkoe == 1'b1, "R1", "lock enable in reset", int'(lkoe), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #3;
        check(pull_dut == '0 && flt == 1'b0, "R1", "idle after reset", int'(flt), 0);

        // A: idle request on line 1 (R2, R3, R4, R12)
        step(0, 0, 1); c = cyc;
        expect_ev(EV_GRANT, 1, c + 1, "R2");
        expect_ev(EV_FLOAT, 0, c + 2, "R3");
        repeat (3) step(0, 0, 0);
        step(0, 0, 1); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R4");
        step(0, 0, 0);
        #3 check(flt == 1'b0, "R4", "float with resume", int'(flt), 0);
        step(0, 0, 0);
        #3 check(sb.size() == 0, "R12", "no extra grant from own pulse", sb.size(), 0);

        // B: both lines at once (R6, R5)
        step(0, 1, 1); c = cyc;
        expect_ev(EV_GRANT, 0, c + 1, "R6");
        expect_ev(EV_FLOAT, 0, c + 2, "R6");
        repeat (2) step(0, 0, 0);
        step(0, 1, 0); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R4");
        expect_ev(EV_GRANT, 1, c + 3, "R5");
        expect_ev(EV_FLOAT, 0, c + 4, "R5");
        repeat (4) step(0, 0, 0);
        step(0, 0, 1); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R5");
        repeat (2) step(0, 0, 0);

        // C: request in T1, grant in T4 (R7)
        step(1, 1, 0); c = cyc;
        expect_ev(EV_GRANT, 0, c + 3, "R7");
        expect_ev(EV_FLOAT, 0, c + 4, "R7");
        step(2, 0, 0); step(3, 0, 0); step(4, 0, 0);
        step(0, 0, 0); step(0, 0, 0);
        step(0, 1, 0); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R7");
        repeat (2) step(0, 0, 0);

        // D: request in T3 waits for next cycle's T4 (R8)
        step(1, 0, 0); step(2, 0, 0);
        step(3, 0, 1); step(4, 0, 0);
        step(1, 0, 0); step(2, 0, 0); step(3, 0, 0);
        step(4, 0, 0); c = cyc;
        expect_ev(EV_GRANT, 1, c, "R8");
        expect_ev(EV_FLOAT, 0, c + 1, "R8");
        step(0, 0, 0); step(0, 0, 0);
        step(0, 0, 1); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R8");
        repeat (2) step(0, 0, 0);

        // E: split word and interrupt acknowledge block T4 (R9)
        step(1, 1, 0); step(2, 0, 0); step(3, 0, 0);
        step(4, 0, 0, 1, 0, 0);
        step(1, 0, 0); step(2, 0, 0); step(3, 0, 0);
        step(4, 0, 0, 0, 1, 0);
        step(1, 0, 0); step(2, 0, 0); step(3, 0, 0);
        step(4, 0, 0); c = cyc;
        expect_ev(EV_GRANT, 0, c, "R9");
        expect_ev(EV_FLOAT, 0, c + 1, "R9");
        step(0, 0, 0); step(0, 0, 0);
        step(0, 1, 0); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R9");
        repeat (2) step(0, 0, 0);

        // F: lock blocks, lock output floats, request during hold (R10, R11, R12)
        step(0, 0, 1, 0, 0, 1);
        #3 check(lkn == 1'b0 && lkoe == 1'b1, "R11", "lock driven low", int'(lkn), 0);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0); c = cyc;
        expect_ev(EV_GRANT, 1, c, "R10");
        expect_ev(EV_FLOAT, 0, c + 1, "R10");
        step(0, 0, 0, 0, 0, 1);
        #3 check(lkoe == 1'b0, "R11", "lock floats in hold", int'(lkoe), 0);
        step(0, 1, 0);
        step(0, 0, 1); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R4");
        expect_ev(EV_GRANT, 0, c + 3, "R12");
        expect_ev(EV_FLOAT, 0, c + 4, "R12");
        step(0, 0, 0);
        #3 check(lkoe == 1'b1 && lkn == 1'b1, "R11", "lock enabled after reclaim", int'(lkoe), 1);
        repeat (4) step(0, 0, 0);
        step(0, 1, 0); c = cyc;
        expect_ev(EV_RESUME, 0, c + 1, "R12");
        repeat (5) step(0, 0, 0);

        #3 check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule